// File: doc/BRIEF.md
# Aging-Counter LRU Replacement Tracker

This block keeps recency order for one set of a set-associative cache. Each way has a small age counter and an occupancy bit. The surrounding cache supplies an access strobe, a hit flag and the index of the hit way. The tracker reports which way should be filled or evicted on the next miss, and whether every way of the set is occupied. Tag storage, the data arrays and hit detection live outside this block.

On a hit, the hit way becomes the youngest. Only the ways that were younger than the hit way's old age grow older. On a miss, the chosen way becomes the youngest and every other way grows older by one. While the set has free ways, a miss fills the lowest-numbered free way. Once the set is full, a miss evicts the way whose age is the maximum. All counters update in the single clock cycle in which the strobe is high.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset every age counter is 0, `set_full` is 0 and `victim_way` is 0.
- R2: An access with `acc_vld`=1 and `acc_hit`=1 to an occupied way clears that way's age to 0. It adds 1 to every age that was strictly below the hit way's previous age. All other ages keep their value.
- R3: While the set is not full, `victim_way` is the lowest-numbered unoccupied way. A miss (`acc_vld`=1, `acc_hit`=0) marks that way occupied and clears its age to 0, and it adds 1 to every other age.
- R4: While the set is full, `victim_way` is the way whose age equals WAYS-1. A miss clears that way's age to 0 and adds 1 to every other age.
- R5: `set_full` is 1 exactly when all ways are occupied. Once it is set, it stays set until reset.
- R6: While the set is full, the ages are pairwise distinct. No counter ever wraps from WAYS-1 to 0 by incrementing.
- R7: A cycle with `acc_vld`=0 changes nothing. A hit that names an unoccupied way also changes nothing. Both are observed on `age_vec`, `set_full` and `victim_way`.
- R8: From reset, the access sequence miss, miss, hit way 0, miss, miss, hit way 1, miss, miss leaves the ages of ways 0..3 at 1, 2, 0, 3. The last two misses evict way 0 and then way 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access strobe; state updates on this edge |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_way | input | CW | Hit way index (used when `acc_hit`=1) |
| victim_way | output | CW | Way to fill or replace on a miss (combinational) |
| set_full | output | 1 | All ways occupied |
| age_vec | output | WAYS*CW | Age of way i at bits [i*CW +: CW] |

## Verification
The hardest state to reach is a full set whose ages form an arbitrary permutation, with the maximum sitting on any way. It is also hard to reach a hit on a way whose age is neither extreme. The stimulus reaches these cases with a long pseudo-random run of hits, misses, idle cycles and hits on empty ways. The run is broken up by periodic resets, so the fill phase is also exercised many times. A bench reference model predicts every age, the full flag and the victim after each step.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
   localparam int DEF_WAYS = 4;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_HIT  = 2'd1,
      OP_MISS = 2'd2
   } lru_op_e;
endpackage

// File: rtl/lru_age_cell.sv
module lru_age_cell #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   input  logic          fill,
   output logic [CW-1:0] age,
   output logic          occ
);
   localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age <= '0;
         occ <= 1'b0;
      end else begin
         if (clr)      age <= '0;
         else if (inc) age <= age + 1'b1;
         if (fill)     occ <= 1'b1;
      end
   end

   // R6: an increment is never requested on a counter already at its top value
   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |-> (age != AGE_MAX));
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
   parameter int WAYS = 4,
   parameter int CW   = 2
) (
   input  logic [WAYS-1:0]         occ,
   input  logic [WAYS-1:0][CW-1:0] ages,
   output logic [CW-1:0]           victim,
   output logic                    full
);
   logic [CW-1:0] first_free;
   logic [CW-1:0] oldest;
   logic [CW-1:0] oldest_age;

   always_comb begin
      first_free = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!occ[i]) first_free = CW'(i);
      end
   end

   always_comb begin
      oldest     = '0;
      oldest_age = ages[0];
      for (int i = 1; i < WAYS; i++) begin
         if (ages[i] > oldest_age) begin
            oldest     = CW'(i);
            oldest_age = ages[i];
         end
      end
   end

   assign full   = &occ;
   assign victim = full ? oldest : first_free;
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
   import lru_age_pkg::*;
#(
   parameter int WAYS = DEF_WAYS,
   parameter int CW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_vld,
   input  logic               acc_hit,
   input  logic [CW-1:0]      acc_way,
   output logic [CW-1:0]      victim_way,
   output logic               set_full,
   output logic [WAYS*CW-1:0] age_vec
);
   localparam logic [CW-1:0] TOP_AGE = CW'(WAYS - 1);

   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("lru_age_tracker: WAYS must be at least 2");
      end
      if ((1 << CW) < WAYS) begin : g_bad_cw
         $error("lru_age_tracker: CW too narrow for WAYS");
      end
   endgenerate

   logic [WAYS-1:0]         occ;
   logic [WAYS-1:0][CW-1:0] ages;
   logic [WAYS-1:0]         clr_w, inc_w, fill_w;
   lru_op_e                 op;
   logic [CW-1:0]           tgt;
   logic [CW-1:0]           hit_age;

   lru_victim_pick #(.WAYS(WAYS), .CW(CW)) u_pick (
      .occ    (occ),
      .ages   (ages),
      .victim (victim_way),
      .full   (set_full)
   );

   always_comb begin
      op = OP_IDLE;
      if (acc_vld && !acc_hit)                   op = OP_MISS;
      else if (acc_vld && acc_hit && occ[acc_way]) op = OP_HIT;
   end

   assign tgt     = (op == OP_HIT) ? acc_way : victim_way;
   assign hit_age = ages[acc_way];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign clr_w[w]  = (op != OP_IDLE) && (tgt == CW'(w));
         assign fill_w[w] = (op == OP_MISS) && (tgt == CW'(w));
         assign inc_w[w]  = (op == OP_HIT)  ? (ages[w] < hit_age) :
                            (op == OP_MISS) ? (tgt != CW'(w)) : 1'b0;

         lru_age_cell #(.CW(CW)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_w[w]),
            .inc   (inc_w[w]),
            .fill  (fill_w[w]),
            .age   (ages[w]),
            .occ   (occ[w])
         );
         assign age_vec[w*CW +: CW] = ages[w];
      end
   endgenerate

   // distinct-age witness for R6
   logic [(1<<CW)-1:0] ages_seen;
   always_comb begin
      ages_seen = '0;
      for (int i = 0; i < WAYS; i++) ages_seen[ages[i]] = 1'b1;
   end

   assert_distinct_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_full |-> ($countones(ages_seen) == WAYS));

   assert_full_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      set_full |=> set_full);

   assert_hit_mru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_hit && occ[acc_way]) |=> (ages[$past(acc_way)] == '0));

   assert_miss_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_hit) |=> (occ[$past(victim_way)] && ages[$past(victim_way)] == '0));

   assert_victim_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_full |-> (ages[victim_way] == TOP_AGE));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_vld) |=> ($stable(age_vec) && $stable(occ)));
endmodule

// File: tb/lru_age_tracker_tb.sv
module lru_age_tracker_tb;
   localparam int WAYS = 4;
   localparam int CW   = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               acc_vld = 1'b0;
   logic               acc_hit = 1'b0;
   logic [CW-1:0]      acc_way = '0;
   logic [CW-1:0]      victim_way;
   logic               set_full;
   logic [WAYS*CW-1:0] age_vec;

   int total = 0;
   int bad   = 0;
   int m_age [WAYS];
   bit m_occ [WAYS];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   lru_age_tracker #(.WAYS(WAYS), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit),
      .acc_way(acc_way), .victim_way(victim_way), .set_full(set_full),
      .age_vec(age_vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit m_full();
      for (int i = 0; i < WAYS; i++) if (!m_occ[i]) return 1'b0;
      return 1'b1;
   endfunction

   function automatic int m_victim();
      if (!m_full()) begin
         for (int i = 0; i < WAYS; i++) if (!m_occ[i]) return i;
      end
      for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) return i;
      return 0;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < WAYS; i++) begin m_age[i] = 0; m_occ[i] = 1'b0; end
   endtask

   task automatic m_step(input bit v, input bit h, input int w);
      int t, old;
      if (!v) return;
      if (h) begin
         if (!m_occ[w]) return;
         old = m_age[w];
         for (int i = 0; i < WAYS; i++) if (m_age[i] < old) m_age[i]++;
         m_age[w] = 0;
      end else begin
         t = m_victim();
         for (int i = 0; i < WAYS; i++) if (i != t) m_age[i]++;
         m_age[t] = 0;
         m_occ[t] = 1'b1;
      end
   endtask

   task automatic check_all(input string tag);
      bit seen [WAYS];
      for (int i = 0; i < WAYS; i++)
         chk($sformatf("%s age[%0d]", tag, i), int'(age_vec[i*CW +: CW]), m_age[i]);
      chk({tag, " full R5"}, int'(set_full), int'(m_full()));
      chk({tag, " victim"}, int'(victim_way), m_victim());
      if (set_full) begin
         for (int i = 0; i < WAYS; i++) seen[i] = 1'b0;
         for (int i = 0; i < WAYS; i++) seen[age_vec[i*CW +: CW]] = 1'b1;
         for (int i = 0; i < WAYS; i++) chk("R6 distinct ages", int'(seen[i]), 1);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_reset();
   endtask

   task automatic access(input bit v, input bit h, input int w, input string tag);
      @(negedge clk);
      acc_vld = v; acc_hit = h; acc_way = CW'(w);
      @(posedge clk);
      m_step(v, h, w);
      @(negedge clk);
      acc_vld = 1'b0;
      check_all(tag);
   endtask

   initial begin
      int w;
      bit h, v;
      do_reset();
      check_all("R1 reset");

      // R8 worked sequence
      access(1, 0, 0, "R8 miss");
      access(1, 0, 0, "R8 miss");
      access(1, 1, 0, "R8 hit0");
      access(1, 0, 0, "R8 miss");
      access(1, 0, 0, "R8 miss");
      access(1, 1, 1, "R8 hit1");
      chk("R8 victim before 1st replace", int'(victim_way), 0);
      access(1, 0, 0, "R8 replace");
      chk("R8 victim before 2nd replace", int'(victim_way), 2);
      access(1, 0, 0, "R8 replace");
      chk("R8 final age0", int'(age_vec[1:0]), 1);
      chk("R8 final age1", int'(age_vec[3:2]), 2);
      chk("R8 final age2", int'(age_vec[5:4]), 0);
      chk("R8 final age3", int'(age_vec[7:6]), 3);

      // R7 ignored accesses
      do_reset();
      access(1, 1, 2, "R7 hit on empty way");
      access(0, 0, 0, "R7 idle");
      access(1, 0, 0, "R3 first fill");
      access(1, 1, 3, "R7 hit on empty way");

      // sweep: R2 hits, R3 fills, R4 replacements, R7 idles
      for (int n = 0; n < 4000; n++) begin
         if (n % 250 == 0) do_reset();
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         v = (lfsr[2:0] != 3'd0);
         h = lfsr[4];
         w = int'(lfsr[7:6]);
         access(v, h, w, !v ? "R7 idle" : h ? "R2 hit" :
                (m_full() ? "R4 replace" : "R3 fill"));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule